// File: doc/BRIEF.md
# Clock-Driven Startup and Soft-Unmute Controller

This block sequences the power state of a sensor node that has neither a reset pin nor an enable pin. It infers the node's state only from the bus bit clock and the frame sync. Both are sampled on a free-running local reference clock. When both are toggling, the node leaves standby. It then counts bit-clock edges to decide when output may turn non-zero and, later, when the data can be trusted. From the first non-zero output it raises a gain factor one step per frame until full scale. That gain is applied to a signed sample stream. If either bus clock stops for longer than a set number of reference cycles, the node drops back to standby and forgets all startup progress.

The sequencer has four states. STANDBY is the reset state; it moves to WARMUP when both clocks are active. WARMUP keeps the output at zero and counts bit-clock edges; it moves to RAMP when the count reaches the non-zero threshold. RAMP raises the gain on each frame-sync edge and moves to FULL when the gain reaches full scale. FULL holds unity gain. From WARMUP, RAMP or FULL, losing either clock returns to STANDBY. Separately, the valid flag rises when the same edge count reaches the valid threshold.

Top module: `clkdrv_unmute_ctrl`

## Requirements
- R1: After reset the controller is in STANDBY, `smp_out` is zero, `smp_out_vld` is low and `data_ok` is low.
- R2: The bit clock counts as stopped when no rising edge of it has been seen for `BCK_IDLE_CYC` reference cycles. A stopped bit clock forces STANDBY, in which every output sample is zero.
- R3: The frame sync counts as stopped when no rising edge of it has been seen for `FS_IDLE_CYC` reference cycles. Leaving STANDBY needs both clocks active, so a running bit clock with no frame sync gives only zero samples.
- R4: In WARMUP every output sample is zero. The bit-clock rising edge on which both clocks first become active is not counted; each later one is. RAMP is entered on the edge that brings the count to `NZ_CYC`.
- R5: On entry to RAMP the gain is 1. Each frame-sync rising edge seen in RAMP adds 1. When the gain reaches 2^`RAMP_SHIFT` the state becomes FULL, and the gain stays there.
- R6: Each output sample is floor(`smp_in` x gain / 2^`RAMP_SHIFT`) in 24-bit two's complement, saturated to the range -2^23 .. 2^23-1. At full gain the output equals the input.
- R7: `data_ok` rises on the bit-clock edge that brings the count to `VALID_CYC`. It stays high until the next entry to STANDBY.
- R8: Entering STANDBY clears the edge count, the gain and `data_ok`. Every later activation repeats the same WARMUP/RAMP sequence from zero.
- R9: Every cycle with `smp_in_vld` high produces exactly one cycle of `smp_out_vld`, one reference cycle later, including while the output is muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Bus bit clock, sampled as data |
| frame_sync | input | 1 | Bus frame sync, sampled as data |
| smp_in | input | 24 | Signed input sample |
| smp_in_vld | input | 1 | Input sample strobe |
| smp_out | output | 24 | Gained, saturated output sample |
| smp_out_vld | output | 1 | Output sample strobe |
| data_ok | output | 1 | Startup complete, data may be used |

## Verification
The assertions assume three things. Both bus clocks hold every level for at least two reference cycles, so each level survives the synchronizer. `VALID_CYC` is not smaller than `NZ_CYC`. The sample strobe is a single-cycle pulse in the reference domain. The stimulus meets these conditions. It runs the bit clock at one eighth of the reference rate, with eight bit clocks per frame. The frame sync rises together with the first bit clock of each frame. The sample strobe is placed five reference cycles after the third bit-clock edge of a frame, well away from any counter or gain update. The non-zero threshold is chosen to fall mid-frame, so the first ramp step is never in doubt.

// File: rtl/clkdrv_unmute_pkg.sv
package clkdrv_unmute_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_WARMUP  = 2'd1,
        ST_RAMP    = 2'd2,
        ST_FULL    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/clk_activity_mon.sv
module clk_activity_mon #(
    parameter int unsigned IDLE_CYC = 24576
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise,
    output logic alive
);
    localparam int unsigned CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [2:0]    sync_q;
    logic [CW-1:0] gap_q;

    // two-flop synchronizer plus one history flop for edge detection
    assign rise  = sync_q[1] & ~sync_q[2];
    assign alive = (gap_q < LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            gap_q  <= LIMIT;
        end else begin
            sync_q <= {sync_q[1:0], raw_in};
            if (rise)
                gap_q <= '0;
            else if (gap_q < LIMIT)
                gap_q <= gap_q + 1'b1;
        end
    end

    assert_edge_revives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> alive);
    assert_idle_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alive && !rise) |=> !alive);
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import clkdrv_unmute_pkg::*;
#(
    parameter int unsigned NZ_CYC     = 4462,
    parameter int unsigned VALID_CYC  = 262144,
    parameter int unsigned RAMP_SHIFT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bck_rise,
    input  logic                fs_rise,
    input  logic                bck_alive,
    input  logic                fs_alive,
    output logic [RAMP_SHIFT:0] gain,
    output logic                data_ok
);
    localparam int unsigned CW = $clog2(VALID_CYC + 1);
    localparam logic [CW-1:0] NZ_L    = CW'(NZ_CYC);
    localparam logic [CW-1:0] VALID_L = CW'(VALID_CYC);
    localparam logic [RAMP_SHIFT:0] GAIN_FULL = {1'b1, {RAMP_SHIFT{1'b0}}};
    localparam logic [RAMP_SHIFT:0] GAIN_LAST = GAIN_FULL - 1'b1;

    seq_state_t          state_q, state_d;
    logic [CW-1:0]       cnt_q;
    logic [RAMP_SHIFT:0] gain_q;
    logic                ok_q;
    logic                both_alive;
    logic [CW-1:0]       cnt_inc;

    assign both_alive = bck_alive && fs_alive;
    assign cnt_inc    = cnt_q + 1'b1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (both_alive) state_d = ST_WARMUP;
            ST_WARMUP: begin
                if (!both_alive)
                    state_d = ST_STANDBY;
                else if (bck_rise && cnt_inc >= NZ_L)
                    state_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (!both_alive)
                    state_d = ST_STANDBY;
                else if (fs_rise && gain_q == GAIN_LAST)
                    state_d = ST_FULL;
            end
            ST_FULL: if (!both_alive) state_d = ST_STANDBY;
            default: state_d = ST_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // counter, gain and valid flag
    always_ff @(posedge clk) begin
        if (!rst_n || state_d == ST_STANDBY) begin
            cnt_q  <= '0;
            gain_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (bck_rise && state_q != ST_STANDBY && cnt_q < VALID_L) begin
                cnt_q <= cnt_inc;
                if (cnt_inc >= VALID_L) ok_q <= 1'b1;
            end
            if (state_q == ST_WARMUP && state_d == ST_RAMP)
                gain_q <= {{RAMP_SHIFT{1'b0}}, 1'b1};
            else if (state_q == ST_RAMP && fs_rise && gain_q < GAIN_FULL)
                gain_q <= gain_q + 1'b1;
        end
    end

    assign gain    = gain_q;
    assign data_ok = ok_q;

    assert_standby_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !both_alive |=> state_q == ST_STANDBY);
    assert_muted_before_ramp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY || state_q == ST_WARMUP) |-> gain_q == '0);
    assert_gain_rises_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STANDBY && both_alive) |=> gain_q >= $past(gain_q));
    assert_full_is_unity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FULL |-> gain_q == GAIN_FULL);
    assert_ok_after_unmute_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ok_q |-> (state_q == ST_RAMP || state_q == ST_FULL));
endmodule

// File: rtl/gain_apply.sv
module gain_apply #(
    parameter int unsigned SMP_W      = 24,
    parameter int unsigned RAMP_SHIFT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SMP_W-1:0]        smp_in,
    input  logic                    smp_in_vld,
    input  logic [RAMP_SHIFT:0]     gain,
    output logic [SMP_W-1:0]        smp_out,
    output logic                    smp_out_vld
);
    localparam int unsigned PW = SMP_W + RAMP_SHIFT + 2;
    localparam logic signed [PW-1:0] SAT_HI = PW'((64'sd1 <<< (SMP_W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] SAT_LO = -SAT_HI - PW'(1);
    localparam logic [RAMP_SHIFT:0]  GAIN_FULL = {1'b1, {RAMP_SHIFT{1'b0}}};

    logic signed [PW-1:0] a_ext, g_ext, prod, scaled;
    logic [SMP_W-1:0]     sat_val;
    logic [SMP_W-1:0]     out_q;
    logic                 vld_q;

    always_comb begin
        a_ext  = {{(PW - SMP_W){smp_in[SMP_W-1]}}, smp_in};
        g_ext  = {{(PW - RAMP_SHIFT - 1){1'b0}}, gain};
        prod   = a_ext * g_ext;
        scaled = prod >>> RAMP_SHIFT;
        if (scaled > SAT_HI)      sat_val = SAT_HI[SMP_W-1:0];
        else if (scaled < SAT_LO) sat_val = SAT_LO[SMP_W-1:0];
        else                      sat_val = scaled[SMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= smp_in_vld;
            if (smp_in_vld) out_q <= sat_val;
        end
    end

    assign smp_out     = out_q;
    assign smp_out_vld = vld_q;

    assert_mute_gives_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_in_vld && gain == '0) |=> smp_out == '0);
    assert_unity_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_in_vld && gain == GAIN_FULL) |=> smp_out == $past(smp_in));
    assert_strobe_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_in_vld |=> smp_out_vld);
    assert_no_spurious_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_in_vld |=> !smp_out_vld);
endmodule

// File: rtl/clkdrv_unmute_ctrl.sv
module clkdrv_unmute_ctrl #(
    parameter int unsigned SMP_W        = 24,
    parameter int unsigned BCK_IDLE_CYC = 24576,
    parameter int unsigned FS_IDLE_CYC  = 24576,
    parameter int unsigned NZ_CYC       = 4462,
    parameter int unsigned VALID_CYC    = 262144,
    parameter int unsigned RAMP_SHIFT   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_clk,
    input  logic             frame_sync,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             smp_in_vld,
    output logic [SMP_W-1:0] smp_out,
    output logic             smp_out_vld,
    output logic             data_ok
);
    localparam int unsigned N_MON = 2;

    logic [N_MON-1:0]    raw_clk, clk_rise, clk_alive;
    logic [RAMP_SHIFT:0] gain;

    assign raw_clk = {frame_sync, bit_clk};

    // index 0 watches the bit clock, index 1 the frame sync
    for (genvar i = 0; i < N_MON; i++) begin : g_mon
        clk_activity_mon #(
            .IDLE_CYC((i == 0) ? BCK_IDLE_CYC : FS_IDLE_CYC)
        ) u_mon (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (raw_clk[i]),
            .rise   (clk_rise[i]),
            .alive  (clk_alive[i])
        );
    end

    startup_sequencer #(
        .NZ_CYC     (NZ_CYC),
        .VALID_CYC  (VALID_CYC),
        .RAMP_SHIFT (RAMP_SHIFT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bck_rise  (clk_rise[0]),
        .fs_rise   (clk_rise[1]),
        .bck_alive (clk_alive[0]),
        .fs_alive  (clk_alive[1]),
        .gain      (gain),
        .data_ok   (data_ok)
    );

    gain_apply #(
        .SMP_W      (SMP_W),
        .RAMP_SHIFT (RAMP_SHIFT)
    ) u_gain (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_in      (smp_in),
        .smp_in_vld  (smp_in_vld),
        .gain        (gain),
        .smp_out     (smp_out),
        .smp_out_vld (smp_out_vld)
    );
endmodule

// File: tb/sim_clkdrv_unmute_ctrl.sv
`timescale 1ns/1ps
module sim_clkdrv_unmute_ctrl;
    localparam int SW    = 24;
    localparam int BIDLE = 40;
    localparam int FIDLE = 200;
    localparam int NZ    = 30;
    localparam int VAL   = 60;
    localparam int SH    = 3;
    localparam int FULL  = 1 << SH;
    localparam int BITS  = 8;   // bit clocks per frame
    localparam int BPER  = 8;   // reference cycles per bit clock

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_clk = 1'b0;
    logic frame_sync = 1'b0;
    logic [SW-1:0] smp_in = '0;
    logic smp_in_vld = 1'b0;
    logic [SW-1:0] smp_out;
    logic smp_out_vld;
    logic data_ok;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string phase_tag = "";

    logic [SW-1:0] q_val[$];
    logic          q_ok[$];
    string         q_tag[$];

    always #2.5 clk = ~clk;

    clkdrv_unmute_ctrl #(
        .SMP_W(SW), .BCK_IDLE_CYC(BIDLE), .FS_IDLE_CYC(FIDLE),
        .NZ_CYC(NZ), .VALID_CYC(VAL), .RAMP_SHIFT(SH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
        .smp_in(smp_in), .smp_in_vld(smp_in_vld), .smp_out(smp_out),
        .smp_out_vld(smp_out_vld), .data_ok(data_ok)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // model of the requirements: expected output for the sample of frame f
    task automatic push_expect(input int f, input logic signed [SW-1:0] s);
        int b, g;
        longint p;
        logic [SW-1:0] v;
        logic ok;
        string tag;
        if (f < 0) begin
            v = '0; ok = 1'b0; tag = "R3";
        end else begin
            b = f * BITS + 2;
            if (b < NZ) begin
                v = '0; ok = 1'b0;
                tag = (phase_tag != "") ? phase_tag : "R4";
            end else begin
                g = 1 + (f - NZ / BITS);
                if (g > FULL) g = FULL;
                p = longint'(s) * longint'(g);
                p = p >>> SH;
                if (p > 64'sd8388607) p = 64'sd8388607;
                if (p < -64'sd8388608) p = -64'sd8388608;
                v = p[SW-1:0];
                ok = (b >= VAL);
                if ((b >= VAL && b - BITS < VAL) || (b < VAL && b + BITS >= VAL)) tag = "R7";
                else if (g < FULL) tag = "R5";
                else tag = "R6";
            end
        end
        q_val.push_back(v);
        q_ok.push_back(ok);
        q_tag.push_back(tag);
    endtask

    // one frame of bus activity; strobe placed five cycles after bit 2 rises
    task automatic run_frame(input bit fs_en, input int f, input bit strobe,
                             input logic signed [SW-1:0] s);
        if (strobe) push_expect(f, s);
        for (int k = 0; k < BITS; k++) begin
            for (int c = 0; c < BPER; c++) begin
                @(negedge clk);
                bit_clk    = (c < BPER / 2);
                frame_sync = fs_en && (k == 0);
                smp_in_vld = strobe && (k == 2) && (c == 5);
                if (strobe && k == 2 && c == 5) smp_in = s;
            end
        end
    endtask

    task automatic quiet_strobe(input string tag, input logic signed [SW-1:0] s);
        q_val.push_back('0);
        q_ok.push_back(1'b0);
        q_tag.push_back(tag);
        @(negedge clk);
        smp_in = s;
        smp_in_vld = 1'b1;
        @(negedge clk);
        smp_in_vld = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    function automatic logic signed [SW-1:0] pattern(input int f);
        if (f == 12) return -24'sd8388608;
        if (f % 3 == 0) return 24'sd7340033 + 24'(f);
        if (f % 3 == 1) return -24'sd5000003 - 24'(f * 7);
        return 24'sd8388607;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && smp_out_vld) begin
            if (q_val.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: actual unexpected output strobe expected none");
            end else begin
                check(q_tag[0], {40'd0, smp_out}, {40'd0, q_val[0]});
                check({q_tag[0], " data_ok"}, {63'd0, data_ok}, {63'd0, q_ok[0]});
                void'(q_val.pop_front());
                void'(q_ok.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 smp_out", {40'd0, smp_out}, 64'd0);
        check("R1 smp_out_vld", {63'd0, smp_out_vld}, 64'd0);
        check("R1 data_ok", {63'd0, data_ok}, 64'd0);

        // R3: bit clock alone keeps the node muted
        for (int i = 0; i < 3; i++) run_frame(1'b0, -1, 1'b1, pattern(i));
        // R4/R5/R6/R7: power-up through ramp to full scale
        for (int f = 0; f <= 12; f++) run_frame(1'b1, f, 1'b1, pattern(f));
        check("R7 data_ok held", {63'd0, data_ok}, 64'd1);

        // R2: bit clock stops, node falls to standby
        @(negedge clk); bit_clk = 1'b0; frame_sync = 1'b0;
        repeat (100) @(negedge clk);
        check("R2 data_ok cleared", {63'd0, data_ok}, 64'd0);
        quiet_strobe("R2", 24'sd1234567);
        quiet_strobe("R2", -24'sd765432);

        // R8: restart repeats the sequence from zero
        phase_tag = "R8";
        for (int i = 0; i < 2; i++) run_frame(1'b0, -1, 1'b1, pattern(i + 1));
        for (int f = 0; f <= 5; f++) run_frame(1'b1, f, 1'b1, pattern(f));

        // R3: frame sync stops while bit clock runs
        for (int i = 0; i < 4; i++) run_frame(1'b0, -1, 1'b0, '0);
        run_frame(1'b0, -1, 1'b1, 24'sd4000000);
        check("R3 data_ok cleared", {63'd0, data_ok}, 64'd0);

        // R8: second restart, valid count starts over
        for (int f = 0; f <= 8; f++) run_frame(1'b1, f, 1'b1, pattern(f + 2));

        repeat (20) @(negedge clk);
        check("R9 all strobes answered", 64'(q_val.size()), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule